// File: doc/BRIEF.md
# Message Digest Engine Register Front-End

This block sits between a 32-bit register bus and a multi-algorithm message-digest core. Software programs the message length in bits and selects the algorithm and the byte-lane order through the control register. It then streams message words into a separate write-only data port. The front-end reorders the bytes of each accepted word, counts the accepted bytes and, once the programmed length is covered, strobes the digest core to finish. The digest words then go into a small result queue, which software drains one word per read.

Misuse is reported instead of being silently absorbed. A data word written while the engine is unconfigured is dropped and flagged. A read of an empty result queue returns zero and is flagged. Every event lands in a sticky status bit with its own enable bit, and one interrupt line combines them. The digest arithmetic is a stand-in stub: it folds each word into a 32-bit accumulator and expands that accumulator into the result words.

Top module: `hash_regfront`

## Requirements
- R1: Writing 1 to the reset register (offset 0x00, bit 0) holds the block in soft reset and writing 0 releases it. While it is held, the result queue is empty, the control and length registers read 0, and writes to them are ignored.
- R2: The message length is a 64-bit bit count: the upper word is at 0x04 and the lower word at 0x08. Completion happens on the accepted word that brings the byte count (4 per word) to at least ceil(bits/8).
- R3: Control bits [1:0] at 0x0C select the algorithm, with codes 0/1/2/3 giving 4/5/7/8 result words. On completion exactly that many words enter the queue. Word i (from 0) equals A ^ (0x9E3779B9 * (i+1)) mod 2^32. A is the accumulator: it is cleared by a control write, and each accepted word w updates it to rotl1(A) ^ w.
- R4: Control bits [9:8] reorder the bytes of each incoming word. Writing the output lanes from bit 31 down, code 0 gives input lanes 3,2,1,0, code 1 gives 0,1,2,3, code 2 gives 2,3,1,0 and code 3 gives 1,0,3,2. Lane k is bits [8k+7:8k].
- R5: A data-port write made while the engine is unconfigured is discarded and sets status bit 3. The engine is unconfigured after any reset and after each completion, until the next control write.
- R6: A read of the result queue (0x1C) while it is empty returns 0 and sets status bit 2.
- R7: A data write in the same cycle as a control write, or in the cycle right after it, is held off with dat_stall. The first word is accepted no earlier than two cycles after the control write.
- R8: Completion sets status bits 0 and 1 together. The result words then pop in order from word 0 up, one per queue read.
- R9: Writing 1s to the clear register (0x18) clears those status bits in one access. An event that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R10: irq is the OR of (status[3:0] AND enable[3:0]), with enable at 0x14. Status (0x10) bit 8 reads as irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a queue read pops) |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| dat_wr | input | 1 | Data port write strobe, held until not stalled |
| dat_wdata | input | 32 | Message word |
| dat_stall | output | 1 | Data write held off this cycle |
| irq | output | 1 | Interrupt line |

## Verification
A status-clear write on the register bus can meet, in the same cycle, an event that sets the same bit, such as a discarded data-port write that raises bit 3. The bench drives both strobes on one clock edge while the engine is held in soft reset. It then reads status and expects bit 3 still set, and afterwards clears it alone and expects zero. The control write and a data write that arrive together form a second collision: there the bench counts the stall cycles and checks that the word still reaches the digest.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int WORD_W  = 32;
  localparam int MAX_DIG = 8;
  localparam logic [31:0] STUB_K = 32'h9E3779B9;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } alg_e;

  function automatic logic [3:0] digest_len(alg_e a);
    case (a)
      ALG_MD5:    return 4'd4;
      ALG_SHA1:   return 4'd5;
      ALG_SHA224: return 4'd7;
      default:    return 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] lane_order(logic [31:0] w, logic [1:0] sel);
    case (sel)
      2'd0:    return w;
      2'd1:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd2:    return {w[23:16], w[31:24], w[15:8], w[7:0]};
      default: return {w[15:8], w[7:0], w[31:24], w[23:16]};
    endcase
  endfunction

  function automatic logic [31:0] stub_fold(logic [31:0] acc, logic [31:0] w);
    return {acc[30:0], acc[31]} ^ w;
  endfunction

  function automatic logic [31:0] stub_word(logic [31:0] acc, int unsigned idx);
    return acc ^ (STUB_K * 32'(idx + 1));
  endfunction

  function automatic logic [63:0] bytes_due(logic [31:0] hi, logic [31:0] lo);
    logic [64:0] b;
    b = {1'b0, hi, lo} + 65'd7;
    return 64'(b[64:3]);
  endfunction
endpackage

// File: rtl/hrf_lane_order.sv
module hrf_lane_order
  import hrf_pkg::*;
(
  input  logic [1:0]  sel,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  assign dout = lane_order(din, sel);
endmodule

// File: rtl/hrf_digest_stub.sv
module hrf_digest_stub
  import hrf_pkg::*;
#(
  parameter int NW = MAX_DIG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               accept,
  input  logic [31:0]        word,
  input  logic               fin,
  output logic               res_vld,
  output logic [NW*32-1:0]   res
);
  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clear)  acc_q <= '0;
    else if (accept) acc_q <= stub_fold(acc_q, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_vld <= 1'b0;
    else        res_vld <= fin && !clear;
  end

  for (genvar i = 0; i < NW; i++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res[i*32 +: 32] <= '0;
      else if (fin) res[i*32 +: 32] <= stub_word(acc_q, i);
    end
  end
endmodule

// File: rtl/hrf_result_queue.sv
module hrf_result_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               load,
  input  logic [PW-1:0]      load_n,
  input  logic [DEPTH*W-1:0] load_data,
  input  logic               pop,
  output logic [W-1:0]       head,
  output logic               empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] cnt_q, rp_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (load) mem_q[i] <= load_data[i*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rp_q  <= '0;
    end else if (flush) begin
      cnt_q <= '0;
      rp_q  <= '0;
    end else if (load) begin
      cnt_q <= load_n;
      rp_q  <= '0;
    end else if (pop && !empty) begin
      rp_q  <= rp_q + 1'b1;
    end
  end

  assign empty = (rp_q == cnt_q);
  assign head  = empty ? '0 : mem_q[rp_q[IW-1:0]];
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hrf_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 32,
  parameter int GAP_CYC = 2,
  parameter int QDEPTH  = MAX_DIG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dat_wr,
  input  logic [31:0]       dat_wdata,
  output logic              dat_stall,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_LNH = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_LNL = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] A_RSQ = ADDR_W'(5'h1C);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int PW = $clog2(QDEPTH + 1);

  // configuration and state
  logic              srst_q;
  logic [31:0]       len_hi_q, len_lo_q;
  alg_e              alg_q;
  logic [1:0]        ord_q;
  logic              cfg_q;
  logic [GW-1:0]     gap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [3:0]        sts_q, en_q;

  // named events
  logic        wr_rst, wr_lnh, wr_lnl, wr_ctl, wr_ena, wr_clr;
  logic        ctl_wr_evt, dat_acc, dat_err, last_word;
  logic        q_rd_evt, q_pop, rd_err_evt, q_load, q_flush, q_empty;
  logic [31:0] q_head, swapped;
  logic [3:0]  sts_set, sts_clr;
  logic [MAX_DIG*32-1:0] dig_vec;

  assign wr_rst = reg_wr && (reg_addr == A_RST);
  assign wr_lnh = reg_wr && (reg_addr == A_LNH) && !srst_q;
  assign wr_lnl = reg_wr && (reg_addr == A_LNL) && !srst_q;
  assign wr_ctl = reg_wr && (reg_addr == A_CTL);
  assign wr_ena = reg_wr && (reg_addr == A_ENA);
  assign wr_clr = reg_wr && (reg_addr == A_CLR);

  assign ctl_wr_evt = wr_ctl && !srst_q;
  assign dat_stall  = dat_wr && (ctl_wr_evt || (cfg_q && (gap_q != '0)));
  assign dat_acc    = dat_wr && !dat_stall && cfg_q;
  assign dat_err    = dat_wr && !dat_stall && !cfg_q;
  assign last_word  = (64'(cnt_q) + 64'd4) >= bytes_due(len_hi_q, len_lo_q);

  assign q_rd_evt   = reg_rd && (reg_addr == A_RSQ);
  assign q_pop      = q_rd_evt && !q_empty;
  assign rd_err_evt = q_rd_evt && q_empty;
  assign q_flush    = srst_q || (wr_rst && reg_wdata[0]);

  assign sts_set = {dat_err, rd_err_evt, q_load, q_load};
  assign sts_clr = wr_clr ? reg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q   <= 1'b0;
      len_hi_q <= '0;
      len_lo_q <= '0;
      alg_q    <= ALG_MD5;
      ord_q    <= '0;
      cfg_q    <= 1'b0;
      gap_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      sts_q    <= '0;
      en_q     <= '0;
    end else begin
      if (wr_rst) srst_q <= reg_wdata[0];
      sts_q  <= (sts_q & ~sts_clr) | sts_set;
      if (wr_ena) en_q <= reg_wdata[3:0];
      done_q <= dat_acc && last_word;
      if (srst_q) begin
        len_hi_q <= '0;
        len_lo_q <= '0;
        alg_q    <= ALG_MD5;
        ord_q    <= '0;
        cfg_q    <= 1'b0;
        gap_q    <= '0;
        cnt_q    <= '0;
        done_q   <= 1'b0;
      end else begin
        if (wr_lnh) len_hi_q <= reg_wdata;
        if (wr_lnl) len_lo_q <= reg_wdata;
        if (ctl_wr_evt) begin
          alg_q <= alg_e'(reg_wdata[1:0]);
          ord_q <= reg_wdata[9:8];
          cfg_q <= 1'b1;
          gap_q <= GW'(GAP_CYC - 1);
          cnt_q <= '0;
        end else begin
          if (gap_q != '0) gap_q <= gap_q - 1'b1;
          if (dat_acc) begin
            cnt_q <= cnt_q + CNT_W'(4);
            if (last_word) cfg_q <= 1'b0;
          end
        end
      end
    end
  end

  hrf_lane_order u_lane (
    .sel  (ord_q),
    .din  (dat_wdata),
    .dout (swapped)
  );

  hrf_digest_stub #(.NW(MAX_DIG)) u_stub (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctl_wr_evt || srst_q),
    .accept  (dat_acc),
    .word    (swapped),
    .fin     (done_q),
    .res_vld (q_load),
    .res     (dig_vec)
  );

  hrf_result_queue #(.DEPTH(QDEPTH), .W(32)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (q_flush),
    .load      (q_load),
    .load_n    (PW'(digest_len(alg_q))),
    .load_data (dig_vec[QDEPTH*32-1:0]),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty)
  );

  assign irq = |(sts_q & en_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_RST:   reg_rdata = {31'b0, srst_q};
        A_LNH:   reg_rdata = len_hi_q;
        A_LNL:   reg_rdata = len_lo_q;
        A_CTL:   reg_rdata = {22'b0, ord_q, 6'b0, alg_q};
        A_STS:   reg_rdata = {23'b0, irq, 4'b0, sts_q};
        A_ENA:   reg_rdata = {28'b0, en_q};
        A_RSQ:   reg_rdata = q_head;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/hash_regfront_chk.sv
module hash_regfront_chk #(
  parameter int GAP_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        srst_q,
  input logic        ctl_wr_evt,
  input logic        dat_wr,
  input logic        dat_stall,
  input logic        dat_err,
  input logic        q_rd_evt,
  input logic        q_empty,
  input logic        q_load,
  input logic [31:0] reg_rdata,
  input logic [3:0]  sts_q,
  input logic [3:0]  en_q,
  input logic        irq
);
  // R1
  srst_queue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> q_empty);

  // R7
  ctl_gap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GAP_CYC >= 2 && ctl_wr_evt) |=> (!dat_wr || dat_stall));

  // R5
  write_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_err |=> sts_q[3]);

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rd_evt && q_empty) |-> (reg_rdata == 32'd0));

  // R6
  empty_read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rd_evt && q_empty) |=> sts_q[2]);

  // R8
  load_sets_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_load |=> (sts_q[1:0] == 2'b11));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'b0) |-> !irq);
endmodule

bind hash_regfront hash_regfront_chk #(.GAP_CYC(GAP_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst_q     (srst_q),
  .ctl_wr_evt (ctl_wr_evt),
  .dat_wr     (dat_wr),
  .dat_stall  (dat_stall),
  .dat_err    (dat_err),
  .q_rd_evt   (q_rd_evt),
  .q_empty    (q_empty),
  .q_load     (q_load),
  .reg_rdata  (reg_rdata),
  .sts_q      (sts_q),
  .en_q       (en_q),
  .irq        (irq)
);

// File: tb/hash_regfront_tb_top.sv
module hash_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, dat_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, dat_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dat_stall, irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hash_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_stall(dat_stall), .irq(irq)
  );

  localparam logic [4:0] O_RST = 5'h00, O_LNH = 5'h04, O_LNL = 5'h08, O_CTL = 5'h0C,
                         O_STS = 5'h10, O_ENA = 5'h14, O_CLR = 5'h18, O_RSQ = 5'h1C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic dwrite(input logic [31:0] w, output int stalls);
    stalls = 0;
    dat_wr = 1'b1; dat_wdata = w;
    #5;
    while (dat_stall) begin
      stalls++;
      @(negedge clk);
      #5;
    end
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of the digest path
  function automatic logic [31:0] m_order(logic [31:0] w, int code);
    logic [7:0] b [4];
    int p [4];
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    case (code)
      0: p = '{3, 2, 1, 0};
      1: p = '{0, 1, 2, 3};
      2: p = '{2, 3, 1, 0};
      default: p = '{1, 0, 3, 2};
    endcase
    return {b[p[0]], b[p[1]], b[p[2]], b[p[3]]};
  endfunction

  function automatic logic [31:0] m_fold(logic [31:0] a, logic [31:0] w);
    return ((a << 1) | (a >> 31)) ^ w;
  endfunction

  function automatic logic [31:0] m_word(logic [31:0] a, int i);
    logic [31:0] k = 32'h0;
    for (int j = 0; j <= i; j++) k = k + 32'h9E3779B9;
    return a ^ k;
  endfunction

  function automatic int m_len(int alg);
    case (alg) 0: return 4; 1: return 5; 2: return 7; default: return 8; endcase
  endfunction

  task automatic configure(input int alg, input int ord, input logic [63:0] bits);
    reg_write(O_LNH, bits[63:32]);
    reg_write(O_LNL, bits[31:0]);
    reg_write(O_CTL, 32'((ord << 8) | alg));
  endtask

  task automatic drain(input string tag, input int n, input logic [31:0] acc);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      reg_read(O_RSQ, d);
      chk(tag, d, m_word(acc, i));
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    reg_read(O_STS, d);  chk("R10 status after reset", d, 32'h0);
    reg_read(O_CTL, d);  chk("R3 control after reset", d, 32'h0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    reg_read(O_RSQ, d);  chk("R6 empty read data", d, 32'h0);
    reg_read(O_STS, d);  chk("R6 read error flag", d, 32'h4);
    reg_write(O_ENA, 32'h4);
    #5 chk("R10 irq when enabled", {31'b0, irq}, 32'h1);
    reg_read(O_STS, d);  chk("R10 status bit 8", d, 32'h104);
    reg_write(O_CLR, 32'h4);
    reg_read(O_STS, d);  chk("R9 clear in one access", d, 32'h0);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    reg_write(O_ENA, 32'h0);
  endtask

  task automatic t_unconfigured_write();
    logic [31:0] d;
    int s;
    dwrite(32'hDEADBEEF, s);
    chk("R5 no stall when unconfigured", 32'(s), 32'h0);
    reg_read(O_STS, d);  chk("R5 write error flag", d, 32'h8);
    reg_write(O_CLR, 32'hF);
  endtask

  task automatic t_orders();
    logic [31:0] d;
    int s;
    for (int ord = 0; ord < 4; ord++) begin
      configure(0, ord, 64'd32);
      reg_read(O_CTL, d);  chk("R4 control readback", d, 32'(ord << 8));
      dwrite(32'h11223344, s);
      idle(4);
      reg_read(O_STS, d);  chk("R8 both completion bits", d, 32'h3);
      reg_write(O_CLR, 32'h3);
      drain("R4 lane order digest", 4, m_fold(32'h0, m_order(32'h11223344, ord)));
      reg_read(O_RSQ, d);  chk("R6 read past digest", d, 32'h0);
      reg_write(O_CLR, 32'h4);
    end
  endtask

  task automatic t_algorithms();
    logic [31:0] d, acc;
    int s;
    for (int alg = 0; alg < 4; alg++) begin
      configure(alg, 0, 64'd64);
      dwrite(32'hA5A50001 + 32'(alg), s);
      dwrite(32'h0F1E2D3C, s);
      acc = m_fold(m_fold(32'h0, 32'hA5A50001 + 32'(alg)), 32'h0F1E2D3C);
      idle(4);
      dwrite(32'h77777777, s);
      reg_read(O_STS, d);  chk("R5 write after completion", d, 32'hB);
      reg_write(O_CLR, 32'hF);
      drain("R3 digest words", m_len(alg), acc);
      reg_read(O_RSQ, d);  chk("R3 queue holds exactly the digest", d, 32'h0);
      reg_read(O_STS, d);  chk("R3 read error after last word", d, 32'h4);
      reg_write(O_CLR, 32'h4);
    end
  endtask

  task automatic t_gap();
    logic [31:0] acc;
    int s;
    configure(0, 0, 64'd32);
    dwrite(32'h00C0FFEE, s);
    chk("R7 stall for data right after control", 32'(s), 32'h1);
    idle(4);
    drain("R7 word after gap reaches digest", 1, m_fold(32'h0, 32'h00C0FFEE));
    reg_write(O_CLR, 32'h3);
    reg_write(O_LNL, 32'd32);
    // control and data on the same edge
    reg_wr = 1'b1; reg_addr = O_CTL; reg_wdata = 32'h0;
    dat_wr = 1'b1; dat_wdata = 32'h12345678;
    #5 s = dat_stall ? 1 : 0;
    @(negedge clk);
    reg_wr = 1'b0;
    #5;
    while (dat_stall) begin s++; @(negedge clk); #5; end
    @(negedge clk);
    dat_wr = 1'b0;
    chk("R7 stall for data with control", 32'(s), 32'h2);
    idle(4);
    acc = m_fold(32'h0, 32'h12345678);
    drain("R7 same-edge word reaches digest", 1, acc);
    reg_write(O_CLR, 32'h3);
  endtask

  task automatic t_length();
    logic [31:0] d;
    int s;
    configure(1, 0, 64'd40);
    dwrite(32'h01010101, s);
    idle(4);
    reg_read(O_STS, d);  chk("R2 not done before byte count", d, 32'h0);
    dwrite(32'h02020202, s);
    idle(4);
    reg_read(O_STS, d);  chk("R2 done on covering word", d, 32'h3);
    reg_write(O_CLR, 32'h3);
    configure(0, 0, 64'h1_0000_0000);
    for (int i = 0; i < 4; i++) dwrite(32'(i), s);
    idle(4);
    reg_read(O_STS, d);  chk("R2 high word counts", d, 32'h0);
    reg_read(O_LNH, d);  chk("R2 high word readback", d, 32'h1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    reg_write(O_RST, 32'h1);
    reg_read(O_RST, d);  chk("R1 reset held", d, 32'h1);
    reg_read(O_CTL, d);  chk("R1 control cleared", d, 32'h0);
    reg_read(O_LNL, d);  chk("R1 length cleared", d, 32'h0);
    reg_write(O_CTL, 32'h303);
    reg_read(O_CTL, d);  chk("R1 control write ignored", d, 32'h0);
    reg_read(O_RSQ, d);  chk("R1 queue emptied", d, 32'h0);
    reg_write(O_CLR, 32'hF);
    // clear of bit 3 on the same edge as an event setting it
    reg_wr = 1'b1; reg_addr = O_CLR; reg_wdata = 32'h8;
    dat_wr = 1'b1; dat_wdata = 32'h55AA55AA;
    @(negedge clk);
    reg_wr = 1'b0; dat_wr = 1'b0;
    reg_read(O_STS, d);  chk("R9 set wins over clear", d, 32'h8);
    reg_write(O_CLR, 32'h8);
    reg_read(O_STS, d);  chk("R9 later clear", d, 32'h0);
    reg_write(O_RST, 32'h0);
    reg_read(O_RST, d);  chk("R1 reset released", d, 32'h0);
  endtask

  task automatic t_queue_before_reset();
    int s;
    configure(2, 0, 64'd32);
    dwrite(32'hCAFE0000, s);
    idle(4);
    reg_write(O_CLR, 32'h3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_state();
    t_empty_read();
    t_unconfigured_write();
    t_orders();
    t_algorithms();
    t_gap();
    t_length();
    t_queue_before_reset();
    t_soft_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired before the end of the scenarios");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule